// File: doc/BRIEF.md
# Software-Raised Interrupt Status Controller

This block holds a word of pending interrupt causes and drives one level-sensitive interrupt line from it. Software posts causes by writing a bit mask to a raise register, which ORs the mask into the pending word. It retires causes by writing a mask to a separate acknowledge register, which clears exactly the bits set in that mask. The pending word itself is the cause word, and software reads it from a read-only status register. Writing the status register changes nothing.

Internal engines can also post causes. Each engine supplies a one-cycle completion pulse and an interrupt-enable level. With the default parameters, engine 0 (factorial completion) posts bit 0 and engine 1 (DMA completion) posts bit 8 (cause value 0x100). The interrupt line is high whenever any pending bit is set. If an engine posts a bit in the same cycle that software acknowledges it, the bit stays pending so that the event is not lost.

Top module: `irq_status_ctrl`

## Requirements
- R1: While `rst_n` is low the pending word is 0 and `irq_o` is low. Asserting reset in the middle of a run clears all pending bits.
- R2: A write with `wr_en` high to offset 0x60 ORs `wr_data` into the pending word. The result is visible one clock edge later, and bits already set are kept.
- R3: A write with `wr_en` high to offset 0x64 clears every pending bit that is 1 in `wr_data` and leaves all other pending bits unchanged. The result is visible one clock edge later.
- R4: `rd_data` shows the pending word when `rd_addr` is 0x24 and shows 0 for any other read offset.
- R5: `irq_o` is high exactly when the pending word is nonzero, in the same cycle as that word.
- R6: Writes to offset 0x24, writes to any offset other than 0x60 or 0x64, and any cycle with `wr_en` low leave the pending word unchanged.
- R7: A pulse on `src_done_i[0]` with `src_irq_en_i[0]` high sets pending bit 0 (the factorial cause). The same pulse with the enable low has no effect.
- R8: A pulse on `src_done_i[1]` with `src_irq_en_i[1]` high sets pending bit 8 (the DMA cause, value 0x100).
- R9: When an engine sets a bit in the same cycle that an acknowledge write clears it, the bit stays set. Other bits named in the same acknowledge are still cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data (mask) |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Read data (pending word at 0x24, else 0) |
| src_done_i | input | 2 | One-cycle completion pulses from internal engines |
| src_irq_en_i | input | 2 | Per-engine interrupt enables |
| irq_o | output | 1 | Level interrupt, high while any cause is pending |

## Verification
A corrupted pending word has two visible effects. The status read at offset 0x24 returns the wrong value, and the interrupt line disagrees with software's expectation on the first cycle after the faulty update. Two faults are especially damaging. If the set-wins rule is lost on an acknowledge collision, an engine event disappears and the line drops one cycle after the acknowledge. If an ignored write leaks into the word, a cause appears that nobody raised. Every stimulus step in the bench is followed, one edge later, by a read of the status register and a check of the line, so any such fault is reported within one cycle.

// File: rtl/isc_pkg.sv
package isc_pkg;

    // Kind of register access decoded from a write
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_RAISE = 2'd1,
        ACC_ACK   = 2'd2,
        ACC_OTHER = 2'd3
    } acc_kind_e;

    // Default register offsets
    localparam int unsigned OFS_STATUS = 'h24;
    localparam int unsigned OFS_RAISE  = 'h60;
    localparam int unsigned OFS_ACK    = 'h64;

endpackage

// File: rtl/isc_regdec.sv
module isc_regdec
    import isc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned RAISE_OFS = OFS_RAISE,
    parameter int unsigned ACK_OFS   = OFS_ACK
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output acc_kind_e         acc,
    output logic [DATA_W-1:0] raise_mask,
    output logic [DATA_W-1:0] ack_mask
);

    localparam logic [ADDR_W-1:0] RaiseA = ADDR_W'(RAISE_OFS);
    localparam logic [ADDR_W-1:0] AckA   = ADDR_W'(ACK_OFS);

    always_comb begin
        acc        = ACC_NONE;
        raise_mask = '0;
        ack_mask   = '0;
        if (wr_en) begin
            if (wr_addr == RaiseA) begin
                acc        = ACC_RAISE;
                raise_mask = wr_data;
            end else if (wr_addr == AckA) begin
                acc      = ACC_ACK;
                ack_mask = wr_data;
            end else begin
                acc = ACC_OTHER;
            end
        end
    end

endmodule

// File: rtl/isc_hwsrc.sv
module isc_hwsrc #(
    parameter int unsigned NSRC   = 2,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SRC_BIT [NSRC] = '{0, 8}
) (
    input  logic [NSRC-1:0]   done,
    input  logic [NSRC-1:0]   en,
    output logic [DATA_W-1:0] set_mask
);

    logic [NSRC-1:0][DATA_W-1:0] per_src;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        initial begin
            if (SRC_BIT[g] >= DATA_W)
                $display("isc_hwsrc: source %0d bit %0d out of range", g, SRC_BIT[g]);
        end
        always_comb begin
            per_src[g] = '0;
            per_src[g][SRC_BIT[g] % DATA_W] = done[g] & en[g];
        end
    end

    always_comb begin
        set_mask = '0;
        for (int i = 0; i < NSRC; i++) set_mask |= per_src[i];
    end

endmodule

// File: rtl/isc_status.sv
module isc_status
    import isc_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_e         acc,
    input  logic [DATA_W-1:0] raise_mask,
    input  logic [DATA_W-1:0] ack_mask,
    input  logic [DATA_W-1:0] set_mask,
    output logic [DATA_W-1:0] status,
    output logic              irq
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              line;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set sources win over acknowledge on the same bit
        st_d.word = (st_q.word & ~(ack_mask & ~set_mask)) | raise_mask | set_mask;
        st_d.line = |st_d.word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.word;
    assign irq    = st_q.line;

    assert_raise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_RAISE) |=> ((status & $past(raise_mask)) == $past(raise_mask)));

    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_ACK) |=> ((status & $past(ack_mask & ~set_mask)) == '0));

    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != ACC_RAISE && set_mask == '0) |=> ((status & ~$past(status)) == '0));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((status & $past(set_mask)) == $past(set_mask)));

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import isc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned NSRC       = 2,
    parameter int unsigned SRC_BIT [NSRC] = '{0, 8},
    parameter int unsigned STATUS_OFS = OFS_STATUS,
    parameter int unsigned RAISE_OFS  = OFS_RAISE,
    parameter int unsigned ACK_OFS    = OFS_ACK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NSRC-1:0]   src_done_i,
    input  logic [NSRC-1:0]   src_irq_en_i,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STATUS_OFS);

    acc_kind_e         acc;
    logic [DATA_W-1:0] raise_mask, ack_mask, set_mask, status;

    isc_regdec #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .RAISE_OFS(RAISE_OFS), .ACK_OFS(ACK_OFS)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .acc(acc), .raise_mask(raise_mask), .ack_mask(ack_mask)
    );

    isc_hwsrc #(
        .NSRC(NSRC), .DATA_W(DATA_W), .SRC_BIT(SRC_BIT)
    ) u_src (
        .done(src_done_i), .en(src_irq_en_i), .set_mask(set_mask)
    );

    isc_status #(.DATA_W(DATA_W)) u_st (
        .clk(clk), .rst_n(rst_n), .acc(acc),
        .raise_mask(raise_mask), .ack_mask(ack_mask), .set_mask(set_mask),
        .status(status), .irq(irq_o)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == StatA) rd_data = status;
    end

    assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == StatA) |-> (irq_o == (|rd_data)));

endmodule

// File: tb/sim_irq_status_ctrl.sv
`timescale 1ns/1ps
module sim_irq_status_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = 8'h24;
    logic [31:0] rd_data;
    logic [1:0]  src_done_i = '0;
    logic [1:0]  src_irq_en_i = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk; // 50 MHz

    irq_status_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .src_done_i(src_done_i), .src_irq_en_i(src_irq_en_i), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [1:0]  done;
        logic [1:0]  en;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h60, 32'h0000_0005, 2'b00, 2'b00, 32'h0000_0005}, // R2
        '{1'b1, 8'h60, 32'h0000_0030, 2'b00, 2'b00, 32'h0000_0035}, // R2
        '{1'b1, 8'h64, 32'h0000_0004, 2'b00, 2'b00, 32'h0000_0031}, // R3
        '{1'b1, 8'h24, 32'hFFFF_FFFF, 2'b00, 2'b00, 32'h0000_0031}, // R6
        '{1'b1, 8'h10, 32'h0000_00FF, 2'b00, 2'b00, 32'h0000_0031}, // R6
        '{1'b0, 8'h60, 32'h0000_FF00, 2'b00, 2'b00, 32'h0000_0031}, // R6
        '{1'b1, 8'h64, 32'h0000_0031, 2'b00, 2'b00, 32'h0000_0000}, // R3
        '{1'b0, 8'h00, 32'h0000_0000, 2'b01, 2'b00, 32'h0000_0000}, // R7
        '{1'b0, 8'h00, 32'h0000_0000, 2'b01, 2'b01, 32'h0000_0001}, // R7
        '{1'b0, 8'h00, 32'h0000_0000, 2'b10, 2'b10, 32'h0000_0101}, // R8
        '{1'b1, 8'h64, 32'h0000_0101, 2'b00, 2'b11, 32'h0000_0000}, // R3
        '{1'b1, 8'h64, 32'h0000_0101, 2'b10, 2'b10, 32'h0000_0100}, // R9
        '{1'b1, 8'h64, 32'h0000_0100, 2'b00, 2'b00, 32'h0000_0000}, // R3
        '{1'b1, 8'h60, 32'h8000_0000, 2'b00, 2'b00, 32'h8000_0000}, // R2
        '{1'b1, 8'h64, 32'h0000_0000, 2'b01, 2'b01, 32'h8000_0001}, // R7
        '{1'b1, 8'h64, 32'h8000_0001, 2'b00, 2'b00, 32'h0000_0000}  // R3
    };

    string tags [NV] = '{"R2", "R2", "R3", "R6", "R6", "R6", "R3", "R7",
                         "R7", "R8", "R3", "R9", "R3", "R2", "R7", "R3"};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // drive one step at negedge, then sample at the following negedge
    task automatic step(input vec_t v);
        wr_en        = v.we;
        wr_addr      = v.addr;
        wr_data      = v.data;
        src_done_i   = v.done;
        src_irq_en_i = v.en;
        @(negedge clk);
        wr_en      = 1'b0;
        src_done_i = '0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 status in reset", rd_data, 32'h0);
        check("R1 irq in reset", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status after reset", rd_data, 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i]);
            rd_addr = 8'h24;
            #1;
            check(tags[i], rd_data, VECS[i].exp);
            check("R5 irq level", {31'b0, irq_o}, {31'b0, VECS[i].exp != 0});
        end

        // R4: other read offsets return zero while a cause is pending
        step('{1'b1, 8'h60, 32'h0000_00A0, 2'b00, 2'b00, 32'h0});
        rd_addr = 8'h60;
        #1 check("R4 read other offset", rd_data, 32'h0);
        rd_addr = 8'h24;
        #1 check("R4 read status", rd_data, 32'h0000_00A0);
        check("R5 irq with pending", {31'b0, irq_o}, 32'h1);

        // R1: reset mid-run clears pending bits
        rst_n = 1'b0;
        #1;
        check("R1 mid-run reset status", rd_data, 32'h0);
        check("R1 mid-run reset irq", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stays clear", rd_data, 32'h0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule